// File: doc/BRIEF.md
# Transmit Message Buffer Controller

This block keeps one outgoing bus message of up to sixteen bytes in flops and passes it, one byte at a time, to a bit-level line engine over a valid/ready handshake. Software fills the bytes, writes the length as the byte count minus one, and then issues a command code. The block turns that command into a stream, and turns the engine's done or error result into a 2-bit status and a one-cycle transmit interrupt.

All control goes through a byte-wide register port. The port has one write strobe, an 8-bit address and a combinational read path. The port also carries three 11-bit signal-free wait times, which the block drives straight to the line engine. A clear-buffer control empties the message for as long as it is held set. It also cancels a transfer that is in progress, and it raises no interrupt when it does so.

Top module: `txmsg_ctrl`

## Requirements
- R1: After reset the block is in this state:
  - status (0x93) reads 0 and count (0x94) reads 0;
  - byte_valid_o, byte_last_o and irq_o are 0;
  - all three wait times are 0.
- R2: Message bytes are written and read at addresses 0x00 to 0x0F, with 0x00 holding the header. The length register at 0x10 keeps only its low 4 bits, which are the byte count minus one. An address that is not mapped reads 0.
- R3: The count register at 0x94 reads 1 once the length register has been written, and 0 after a clear or a drop.
- R4: Command code 1, written to 0x11 while the status is 0, 2 or 3 and a message is loaded, sets the status to 1 (busy). It then presents bytes 0 through length in order on byte_data_o, with byte_last_o set on the final byte. byte_valid_o is high only while the status is busy.
- R5: While byte_valid_o is high and byte_ready_i is low, the presented byte stays the same.
- R6: A done result sets the status to 2 and an error result sets it to 3. Either result produces exactly one cycle of irq_o.
- R7: Command code 2 while busy stops the stream in the same cycle, sets the status to 3 and pulses irq_o once. While not busy, it has no effect.
- R8: The status 2 or 3 holds until command 0 (which sets the status to 0) or command 1 (which restarts the transfer) is written. Command 0 while busy has no effect.
- R9: Command code 3 while not busy discards the message: count becomes 0 and status becomes 0. A following command 1 starts nothing.
- R10: While bit 0 of 0x13 is 1, the buffer is held empty:
  - the bytes and the length read 0, and the count reads 0;
  - writes to the buffer are ignored;
  - any transfer stops with status 0 and no interrupt.
  Normal writes resume once the bit is 0 again.
- R11: Wait time k (k = 0, 1, 2) takes its low byte at address 0x40+2k and its 3 high bits at address 0x41+2k. Higher written bits are dropped. Wait time k drives sft_o[11k+10:11k].
- R12: Writes to the message bytes or to the length while busy are ignored.
- R13: Address 0x11 reads back the last command code written, in 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 8 | register address |
| reg_wdata_i | input | 8 | register write data |
| reg_rdata_o | output | 8 | register read data (combinational on address) |
| byte_valid_o | output | 1 | message byte offered to line engine |
| byte_data_o | output | 8 | offered byte |
| byte_last_o | output | 1 | offered byte is the final one |
| byte_ready_i | input | 1 | line engine accepts the byte |
| eng_done_i | input | 1 | line engine: message sent |
| eng_err_i | input | 1 | line engine: message failed |
| sft_o | output | 33 | three packed 11-bit signal-free wait times |
| irq_o | output | 1 | transmit interrupt pulse |

## Verification
The hardest states to reach are those in which a control action lands in the middle of a stream:
- an abort, or a held clear, arriving while a byte is waiting on a stalled handshake;
- a buffer write arriving in that same stalled window.

The bench reaches these states by starting a transfer with the engine model's ready held low, which parks the block in busy at byte 0. It then issues the command, the clear or the write, and observes the effect through status, valid and the interrupt. A full sixteen-byte message checks the wrap of the 4-bit index at the top of the buffer.

// File: rtl/txmsg_pkg.sv
package txmsg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_OK   = 2'd2,
    ST_ERR  = 2'd3
  } tx_stat_e;

  localparam logic [1:0] CMD_NOP   = 2'd0;
  localparam logic [1:0] CMD_SEND  = 2'd1;
  localparam logic [1:0] CMD_ABORT = 2'd2;
  localparam logic [1:0] CMD_DROP  = 2'd3;

  localparam logic [7:0] ADR_LEN  = 8'h10;
  localparam logic [7:0] ADR_CMD  = 8'h11;
  localparam logic [7:0] ADR_CLR  = 8'h13;
  localparam logic [7:0] ADR_SFT  = 8'h40;
  localparam logic [7:0] ADR_STAT = 8'h93;
  localparam logic [7:0] ADR_CNT  = 8'h94;
endpackage

// File: rtl/txmsg_store.sv
module txmsg_store #(
  parameter int MSG_BYTES = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_byte_i,
  input  logic              wr_len_i,
  input  logic              drop_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  str_idx_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic [DATA_W-1:0] str_byte_o,
  output logic [IDX_W-1:0]  len_o,
  output logic              loaded_o
);
  logic [DATA_W-1:0] mem_q [MSG_BYTES];
  logic [IDX_W-1:0]  len_q;
  logic              loaded_q;

  for (genvar g = 0; g < MSG_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[g] <= '0;
      else if (clr_i)                                    mem_q[g] <= '0;
      else if (wr_byte_i && idx_i == IDX_W'(g))          mem_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      loaded_q <= 1'b0;
    end else if (clr_i) begin
      len_q    <= '0;
      loaded_q <= 1'b0;
    end else if (wr_len_i) begin
      len_q    <= wr_data_i[IDX_W-1:0];
      loaded_q <= 1'b1;
    end else if (drop_i) begin
      loaded_q <= 1'b0;
    end
  end

  assign rd_byte_o  = mem_q[idx_i];
  assign str_byte_o = mem_q[str_idx_i];
  assign len_o      = len_q;
  assign loaded_o   = loaded_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!loaded_o && len_o == '0)) else $error("clear left data"); // R10
  AST_DROP_UNLOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && !wr_len_i) |=> !loaded_o) else $error("drop kept message"); // R9
endmodule

// File: rtl/txmsg_sft.sv
module txmsg_sft #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int SFT_W   = 11,
  parameter int SFT_NUM = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [SFT_NUM*SFT_W-1:0] sft_o,
  output logic                     rd_hit_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  import txmsg_pkg::*;
  localparam int HI_W = SFT_W - DATA_W;

  logic [DATA_W-1:0] lo_q [SFT_NUM];
  logic [HI_W-1:0]   hi_q [SFT_NUM];

  for (genvar g = 0; g < SFT_NUM; g++) begin : g_sft
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(int'(ADR_SFT) + 2*g);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(int'(ADR_SFT) + 2*g + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (we_i) begin
        if (addr_i == A_LO) lo_q[g] <= wdata_i;
        if (addr_i == A_HI) hi_q[g] <= wdata_i[HI_W-1:0];
      end
    end
    assign sft_o[g*SFT_W +: SFT_W] = {hi_q[g], lo_q[g]};
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    for (int i = 0; i < SFT_NUM; i++) begin
      if (addr_i == ADDR_W'(int'(ADR_SFT) + 2*i)) begin
        rd_hit_o  = 1'b1;
        rd_data_o = lo_q[i];
      end
      if (addr_i == ADDR_W'(int'(ADR_SFT) + 2*i + 1)) begin
        rd_hit_o  = 1'b1;
        rd_data_o = {{(DATA_W-HI_W){1'b0}}, hi_q[i]};
      end
    end
  end

  AST_SFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sft_o)) else $error("wait time moved"); // R11
endmodule

// File: rtl/txmsg_seq.sv
module txmsg_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_i,
  input  logic             loaded_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             byte_ready_i,
  input  logic             eng_done_i,
  input  logic             eng_err_i,
  output logic [1:0]       stat_o,
  output logic [1:0]       cmd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             byte_valid_o,
  output logic             byte_last_o,
  output logic             drop_o,
  output logic             irq_o
);
  import txmsg_pkg::*;

  typedef enum logic [1:0] {PH_OFF, PH_SEND, PH_WAIT} phase_e;

  tx_stat_e         stat_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       cmd_q;
  logic             irq_q;
  logic             busy, abort_hit, result_hit, last_hs;

  assign busy       = (stat_q == ST_BUSY);
  assign abort_hit  = cmd_we_i && cmd_i == CMD_ABORT && busy;
  assign result_hit = busy && (eng_done_i || eng_err_i);
  assign last_hs    = byte_valid_o && byte_ready_i && byte_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= ST_IDLE;
      phase_q <= PH_OFF;
      idx_q   <= '0;
      cmd_q   <= CMD_NOP;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cmd_we_i && !clr_i) cmd_q <= cmd_i;
      if (clr_i) begin
        stat_q  <= ST_IDLE;
        phase_q <= PH_OFF;
        idx_q   <= '0;
      end else if (abort_hit) begin
        stat_q  <= ST_ERR;
        phase_q <= PH_OFF;
        irq_q   <= 1'b1;
      end else if (result_hit) begin
        stat_q  <= eng_err_i ? ST_ERR : ST_OK;
        phase_q <= PH_OFF;
        irq_q   <= 1'b1;
      end else if (busy) begin
        if (byte_valid_o && byte_ready_i) begin
          if (last_hs) phase_q <= PH_WAIT;
          else         idx_q   <= idx_q + 1'b1;
        end
      end else if (cmd_we_i) begin
        unique case (cmd_i)
          CMD_SEND: if (loaded_i) begin
            stat_q  <= ST_BUSY;
            phase_q <= PH_SEND;
            idx_q   <= '0;
          end
          CMD_NOP, CMD_DROP: stat_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign drop_o       = cmd_we_i && cmd_i == CMD_DROP && !busy && !clr_i;
  assign byte_valid_o = (phase_q == PH_SEND);
  assign byte_last_o  = byte_valid_o && (idx_q == len_i);
  assign stat_o       = stat_q;
  assign cmd_o        = cmd_q;
  assign idx_o        = idx_q;
  assign irq_o        = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o) else $error("irq longer than one cycle"); // R6
  AST_IRQ_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_o == ST_OK || stat_o == ST_ERR)) else $error("irq without result"); // R6
  AST_VALID_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> stat_o == ST_BUSY) else $error("valid while not busy"); // R4
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && !clr_i && !abort_hit && !result_hit)
      |=> (byte_valid_o && $stable(idx_o))) else $error("offered byte moved"); // R5
  AST_ABORT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_hit && !clr_i) |=> (stat_o == ST_ERR && !byte_valid_o && irq_o)) else $error("abort"); // R7
endmodule

// File: rtl/txmsg_ctrl.sv
module txmsg_ctrl #(
  parameter int MSG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SFT_W     = 11,
  parameter int SFT_NUM   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic                     byte_valid_o,
  output logic [DATA_W-1:0]        byte_data_o,
  output logic                     byte_last_o,
  input  logic                     byte_ready_i,
  input  logic                     eng_done_i,
  input  logic                     eng_err_i,
  output logic [SFT_NUM*SFT_W-1:0] sft_o,
  output logic                     irq_o
);
  import txmsg_pkg::*;

  localparam int                IDX_W   = $clog2(MSG_BYTES);
  localparam logic [ADDR_W-1:0] MSG_LIM = ADDR_W'(MSG_BYTES);

  logic              clr_q;
  logic              busy, in_msg, wr_byte, wr_len, cmd_we, drop;
  logic [1:0]        stat, cmd;
  logic [IDX_W-1:0]  idx, len;
  logic              loaded;
  logic [DATA_W-1:0] rd_byte, sft_rd;
  logic              sft_hit;

  assign busy    = (stat == ST_BUSY);
  assign in_msg  = (reg_addr_i < MSG_LIM);
  assign wr_byte = reg_we_i && in_msg && !busy;
  assign wr_len  = reg_we_i && reg_addr_i == ADR_LEN && !busy;
  assign cmd_we  = reg_we_i && reg_addr_i == ADR_CMD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   clr_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == ADR_CLR)    clr_q <= reg_wdata_i[0];
  end

  txmsg_store #(.MSG_BYTES(MSG_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_q),
    .wr_byte_i (wr_byte),
    .wr_len_i  (wr_len),
    .drop_i    (drop),
    .idx_i     (reg_addr_i[IDX_W-1:0]),
    .wr_data_i (reg_wdata_i),
    .str_idx_i (idx),
    .rd_byte_o (rd_byte),
    .str_byte_o(byte_data_o),
    .len_o     (len),
    .loaded_o  (loaded)
  );

  txmsg_sft #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFT_W(SFT_W), .SFT_NUM(SFT_NUM)) u_sft (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .sft_o    (sft_o),
    .rd_hit_o (sft_hit),
    .rd_data_o(sft_rd)
  );

  txmsg_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_q),
    .cmd_we_i    (cmd_we),
    .cmd_i       (reg_wdata_i[1:0]),
    .loaded_i    (loaded),
    .len_i       (len),
    .byte_ready_i(byte_ready_i),
    .eng_done_i  (eng_done_i),
    .eng_err_i   (eng_err_i),
    .stat_o      (stat),
    .cmd_o       (cmd),
    .idx_o       (idx),
    .byte_valid_o(byte_valid_o),
    .byte_last_o (byte_last_o),
    .drop_o      (drop),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (in_msg)                       reg_rdata_o = rd_byte;
    else if (reg_addr_i == ADR_LEN)   reg_rdata_o = DATA_W'(len);
    else if (reg_addr_i == ADR_CMD)   reg_rdata_o = DATA_W'(cmd);
    else if (reg_addr_i == ADR_CLR)   reg_rdata_o = DATA_W'(clr_q);
    else if (reg_addr_i == ADR_STAT)  reg_rdata_o = DATA_W'(stat);
    else if (reg_addr_i == ADR_CNT)   reg_rdata_o = DATA_W'(loaded);
    else if (sft_hit)                 reg_rdata_o = sft_rd;
  end

  AST_BUSY_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !clr_q) |=> $stable(len)) else $error("length changed while busy"); // R12
  AST_SEND_NEEDS_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_valid_o) |-> $past(loaded)) else $error("sent empty buffer"); // R9
endmodule

// File: tb/txmsg_ctrl_tb.sv
module txmsg_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        valid, last, ready = 1'b0, done = 1'b0, err = 1'b0, irq;
  logic [7:0]  bdata;
  logic [32:0] sft;

  int checks = 0, fails = 0, irq_n = 0, rx_n = 0;
  logic [7:0] rx_b [32];
  logic       rx_l [32];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  txmsg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .byte_valid_o(valid),
    .byte_data_o(bdata), .byte_last_o(last), .byte_ready_i(ready),
    .eng_done_i(done), .eng_err_i(err), .sft_o(sft), .irq_o(irq)
  );

  // line engine model: record accepted bytes and interrupts
  always @(posedge clk) begin
    if (rst_ni) begin
      if (valid && ready && rx_n < 32) begin
        rx_b[rx_n] = bdata;
        rx_l[rx_n] = last;
        rx_n++;
      end
      if (irq) irq_n++;
    end
  end

  // {addr, wdata, expected readback}
  localparam logic [23:0] VEC [9] = '{
    {8'h00, 8'h5A, 8'h5A},   // R2
    {8'h0F, 8'hC3, 8'hC3},   // R2
    {8'h10, 8'hFF, 8'h0F},   // R2 length keeps 4 bits
    {8'h40, 8'h18, 8'h18},   // R11
    {8'h41, 8'hF9, 8'h01},   // R11 high part 3 bits
    {8'h42, 8'h00, 8'h00},   // R11
    {8'h45, 8'hFA, 8'h02},   // R11
    {8'h44, 8'hAA, 8'hAA},   // R11
    {8'h7E, 8'h33, 8'h00}    // R2 unmapped
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 200 && rx_n < n; t++) @(negedge clk);
  endtask

  logic [7:0] v;
  int irq_base;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h93, v); chk("R1 status", v, 0);
    rd(8'h94, v); chk("R1 count", v, 0);
    chk("R1 valid/last/irq", {valid, last, irq}, 0);
    chk("R1 wait times", sft, 0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      chk("R2/R11 table", v, VEC[i][7:0]);
    end
    chk("R11 packed wait times", sft, {11'h2AA, 11'h000, 11'h118});

    // load 3-byte message
    wr(8'h00, 8'hA1); wr(8'h01, 8'hB2); wr(8'h02, 8'hC3); wr(8'h10, 8'h02);
    rd(8'h94, v); chk("R3 count loaded", v, 1);

    // R4/R5 stalled start
    rx_n = 0; ready = 1'b0;
    wr(8'h11, 8'h01);
    rd(8'h93, v); chk("R4 busy", v, 1);
    chk("R4 first byte", {valid, bdata}, {1'b1, 8'hA1});
    repeat (3) @(negedge clk);
    chk("R5 held byte", {valid, bdata}, {1'b1, 8'hA1});
    wr(8'h00, 8'h55); wr(8'h10, 8'h07);
    rd(8'h00, v); chk("R12 byte write ignored", v, 8'hA1);
    rd(8'h10, v); chk("R12 length write ignored", v, 8'h02);

    ready = 1'b1;
    wait_rx(3);
    @(negedge clk);
    ready = 1'b0;
    chk("R4 order", {rx_b[0], rx_b[1], rx_b[2]}, 24'hA1B2C3);
    chk("R4 last flag", {rx_l[0], rx_l[1], rx_l[2]}, 3'b001);
    chk("R4 valid drops after last", valid, 0);
    rd(8'h93, v); chk("R4 busy awaiting result", v, 1);

    // R6 done
    done = 1'b1; @(negedge clk); done = 1'b0;
    rd(8'h93, v); chk("R6 status ok", v, 2);
    chk("R6 irq high", irq, 1);
    @(negedge clk);
    chk("R6 irq one cycle", irq, 0);
    repeat (4) @(negedge clk);
    rd(8'h93, v); chk("R8 ok holds", v, 2);
    wr(8'h11, 8'h00);
    rd(8'h93, v); chk("R8 cmd0 to idle", v, 0);

    // R6 error result
    rx_n = 0;
    wr(8'h11, 8'h01);
    err = 1'b1; @(negedge clk); err = 1'b0;
    rd(8'h93, v); chk("R6 status error", v, 3);
    chk("R6 irq on error", irq, 1);

    // R8 restart from error, R7 abort while stalled
    wr(8'h11, 8'h01);
    rd(8'h93, v); chk("R8 restart from error", v, 1);
    wr(8'h11, 8'h00);
    rd(8'h93, v); chk("R8 cmd0 while busy ignored", v, 1);
    irq_base = irq_n;
    wr(8'h11, 8'h02);
    rd(8'h93, v); chk("R7 abort status", v, 3);
    chk("R7 abort stops stream, irq", {valid, irq}, 2'b01);
    @(negedge clk);
    chk("R7 one irq", irq_n - irq_base, 1);

    wr(8'h11, 8'h00);
    irq_base = irq_n;
    wr(8'h11, 8'h02);
    repeat (2) @(negedge clk);
    rd(8'h93, v); chk("R7 abort idle no effect", v, 0);
    chk("R7 no irq when idle", irq_n - irq_base, 0);
    rd(8'h11, v); chk("R13 cmd readback", v, 2);

    // R9 drop
    wr(8'h11, 8'h03);
    rd(8'h94, v); chk("R9 count after drop", v, 0);
    rd(8'h93, v); chk("R9 status after drop", v, 0);
    wr(8'h11, 8'h01);
    rd(8'h93, v); chk("R9 send without message", {v, 7'd0, valid}, 0);

    // R10 clear during stalled transfer
    wr(8'h10, 8'h02);
    wr(8'h11, 8'h01);
    irq_base = irq_n;
    wr(8'h13, 8'h01);
    @(negedge clk);
    rd(8'h93, v); chk("R10 status idle", v, 0);
    chk("R10 stream stopped", valid, 0);
    rd(8'h94, v); chk("R10 count zero", v, 0);
    rd(8'h00, v); chk("R10 byte zero", v, 0);
    wr(8'h00, 8'h77);
    rd(8'h00, v); chk("R10 write ignored", v, 0);
    chk("R10 no irq", irq_n - irq_base, 0);
    wr(8'h13, 8'h00);
    wr(8'h00, 8'h77);
    rd(8'h00, v); chk("R10 resumes", v, 8'h77);

    // full 16-byte message
    for (int i = 0; i < 16; i++) wr(8'(i), 8'(i*3+1));
    wr(8'h10, 8'h0F);
    rx_n = 0; ready = 1'b1;
    wr(8'h11, 8'h01);
    wait_rx(16);
    @(negedge clk);
    ready = 1'b0;
    chk("R4 sixteen bytes", rx_n, 16);
    for (int i = 0; i < 16; i++) chk("R4 full byte", {rx_b[i], rx_l[i]}, {8'(i*3+1), i == 15});
    done = 1'b1; @(negedge clk); done = 1'b0;
    rd(8'h93, v); chk("R6 full done", v, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule